// File: doc/BRIEF.md
# Counter Target and Range Comparator

This block watches the 32-bit present value of a pulse counter and turns particular count values into tagged interrupt events. It has two modes. In target mode it holds a table of armed target values, and an entry fires when the count moves onto its value. In range mode it holds a table of armed windows, each with a lower and an upper limit. Each window gives a level status bit, and it fires an event when the count enters the window. Every entry carries its own interrupt tag. The event stream carries that tag to a dispatcher outside the block.

Software fills the tables and the control word through a single-cycle write port. The counter side supplies the present value, a flag that says whether the count is signed, and a pulse for each counter reset. A control bit sets the response to a counter reset: comparison either carries on or switches itself off until software enables it again.

Events leave over a valid/ready stream. Once `irq_valid` is high, it stays high and `irq_id` keeps its value until a cycle in which `irq_ready` is also high. While the consumer stalls, newly matched entries wait in a pending mask that has one bit per entry. An entry that fires again while its bit is already set merges into that bit. A stall never stops the comparison itself.

Top module: `cnt_cmp_unit`

## Requirements
- R1: After reset, `cmp_en_o`, `irq_valid` and `rng_status` are all zero, every table entry is disarmed and the unit is in target mode.
- R2: In target mode, an armed entry produces exactly one event carrying its tag on the clock edge where `cnt_value` differs from the value sampled at the previous edge and equals the entry's target. Holding the count at that value produces no further event.
- R3: Write kinds on `wr_kind` are 0 control, 1 target value, 2 target tag, 3 range lower limit, 4 range upper limit, 5 range tag, with `wr_idx` selecting the entry. A tag write stores `wr_data[IDW-1:0]` as the tag and `wr_data[IDW]` as the arm bit. An entry whose arm bit is 0 never fires and never shows status.
- R4: In range mode, an armed and active entry is inside its window when lower ≤ count ≤ upper. The comparison is two's-complement when `cnt_signed` is 1 and unsigned when it is 0. `rng_status[j]` shows this for the count sampled at the previous edge.
- R5: In range mode, an entry fires once when it passes from outside its window to inside it. This includes the first enabled sample when the count already sits inside.
- R6: Control bit 3 selects the range table size: 1 uses every range entry, and 0 uses only entries 0 to NARROW-1. The other entries then neither fire nor show status.
- R7: With control bit 2 set, a `cnt_clear` pulse clears the enable bit at that edge, and the sample taken with the pulse produces no event. With bit 2 clear, comparison continues and the value presented with the pulse is compared normally.
- R8: When several entries fire at the same edge, the lowest-numbered one is presented first. The others are delivered afterwards in ascending entry order.
- R9: While `irq_valid` is high and `irq_ready` is low, `irq_valid` stays high and `irq_id` does not change.
- R10: With control bit 0 (enable) clear, no new events are produced and `rng_status` reads zero. An event already on the output is still delivered.
- R11: A control write that changes the mode (bit 1) or the range size (bit 3) discards the pending mask. An event already presented on the output is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_value | input | CW | Counter present value |
| cnt_signed | input | 1 | 1: count ordering is two's complement |
| cnt_clear | input | 1 | Pulse marking a counter reset |
| wr_en | input | 1 | Table/control write strobe |
| wr_kind | input | 3 | Write kind (see R3) |
| wr_idx | input | IW | Entry index for table writes |
| wr_data | input | CW | Write data |
| cmp_en_o | output | 1 | Current compare-enable bit |
| rng_status | output | NRNG | Per-range in-window level |
| irq_valid | output | 1 | Event available |
| irq_ready | input | 1 | Consumer accepts event |
| irq_id | output | IDW | Tag of the presented event |

## Verification
A corrupted previous-count register shows up as a missing or repeated target event on the edge where the count moves, so one cycle after the stimulus. A stale window-status register shows up at once on `rng_status` and as a missed or duplicated entry event. Near-exhaustive count sweeps compare both against arithmetic expectations for each step. Damage to the pending mask or the output register shows up as wrong event order, or as lost or extra events during the drain that follows a multi-entry match under back-pressure.

// File: rtl/ccu_pkg.sv
package ccu_pkg;

  typedef enum logic [2:0] {
    WK_CTRL    = 3'd0,
    WK_TGT_VAL = 3'd1,
    WK_TGT_TAG = 3'd2,
    WK_RNG_LO  = 3'd3,
    WK_RNG_HI  = 3'd4,
    WK_RNG_TAG = 3'd5
  } wr_kind_e;

  // control word bit positions
  localparam int CB_EN   = 0;
  localparam int CB_MODE = 1;
  localparam int CB_STOP = 2;
  localparam int CB_WIDE = 3;

endpackage

// File: rtl/ccu_regs.sv
module ccu_regs
  import ccu_pkg::*;
#(
  parameter int CW   = 32,
  parameter int IDW  = 8,
  parameter int NTGT = 48,
  parameter int NRNG = 32,
  parameter int IW   = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [2:0]                 wr_kind,
  input  logic [IW-1:0]              wr_idx,
  input  logic [CW-1:0]              wr_data,
  input  logic                       cnt_clear,
  output logic                       en_q,
  output logic                       mode_q,
  output logic                       stop_q,
  output logic                       wide_q,
  output logic                       cfg_flush,
  output logic [NTGT-1:0][CW-1:0]    tgt_val,
  output logic [NTGT-1:0][IDW-1:0]   tgt_tag,
  output logic [NTGT-1:0]            tgt_arm,
  output logic [NRNG-1:0][CW-1:0]    rng_lo,
  output logic [NRNG-1:0][CW-1:0]    rng_hi,
  output logic [NRNG-1:0][IDW-1:0]   rng_tag,
  output logic [NRNG-1:0]            rng_arm
);

  logic ctrl_wr;
  assign ctrl_wr = wr_en && (wr_kind == WK_CTRL);

  // a change of mode or table size invalidates queued entry numbers
  assign cfg_flush = ctrl_wr &&
                     ((wr_data[CB_MODE] != mode_q) || (wr_data[CB_WIDE] != wide_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      mode_q <= 1'b0;
      stop_q <= 1'b0;
      wide_q <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        mode_q <= wr_data[CB_MODE];
        stop_q <= wr_data[CB_STOP];
        wide_q <= wr_data[CB_WIDE];
      end
      if (cnt_clear && stop_q)
        en_q <= 1'b0;
      else if (ctrl_wr)
        en_q <= wr_data[CB_EN];
    end
  end

  for (genvar i = 0; i < NTGT; i++) begin : g_tgt
    logic sel;
    assign sel = wr_en && (wr_idx == IW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tgt_val[i] <= '0;
        tgt_tag[i] <= '0;
        tgt_arm[i] <= 1'b0;
      end else if (sel) begin
        if (wr_kind == WK_TGT_VAL)
          tgt_val[i] <= wr_data;
        else if (wr_kind == WK_TGT_TAG) begin
          tgt_tag[i] <= wr_data[IDW-1:0];
          tgt_arm[i] <= wr_data[IDW];
        end
      end
    end
  end

  for (genvar j = 0; j < NRNG; j++) begin : g_rng
    logic sel;
    assign sel = wr_en && (wr_idx == IW'(j));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rng_lo[j]  <= '0;
        rng_hi[j]  <= '0;
        rng_tag[j] <= '0;
        rng_arm[j] <= 1'b0;
      end else if (sel) begin
        case (wr_kind)
          WK_RNG_LO: rng_lo[j] <= wr_data;
          WK_RNG_HI: rng_hi[j] <= wr_data;
          WK_RNG_TAG: begin
            rng_tag[j] <= wr_data[IDW-1:0];
            rng_arm[j] <= wr_data[IDW];
          end
          default: ;
        endcase
      end
    end
  end

endmodule

// File: rtl/ccu_match.sv
module ccu_match #(
  parameter int CW     = 32,
  parameter int NTGT   = 48,
  parameter int NRNG   = 32,
  parameter int NARROW = 8,
  parameter int NE     = 48
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [CW-1:0]            cnt_value,
  input  logic                     cnt_signed,
  input  logic                     en_eff,
  input  logic                     mode_rng,
  input  logic                     wide,
  input  logic [NTGT-1:0][CW-1:0]  tgt_val,
  input  logic [NTGT-1:0]          tgt_arm,
  input  logic [NRNG-1:0][CW-1:0]  rng_lo,
  input  logic [NRNG-1:0][CW-1:0]  rng_hi,
  input  logic [NRNG-1:0]          rng_arm,
  output logic [NE-1:0]            hit,
  output logic [NRNG-1:0]          status
);

  function automatic logic ord_le(input logic [CW-1:0] a, input logic [CW-1:0] b,
                                  input logic sgn);
    if (sgn) return $signed(a) <= $signed(b);
    return a <= b;
  endfunction

  logic [CW-1:0]   prev_q;
  logic            moved;
  logic            tgt_on, rng_on;
  logic [NTGT-1:0] t_hit;
  logic [NRNG-1:0] in_now, in_q, r_hit;

  assign moved  = (cnt_value != prev_q);
  assign tgt_on = en_eff && !mode_rng;
  assign rng_on = en_eff && mode_rng;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= cnt_value;
  end

  for (genvar i = 0; i < NTGT; i++) begin : g_t
    assign t_hit[i] = tgt_on && tgt_arm[i] && moved && (cnt_value == tgt_val[i]);
  end

  for (genvar j = 0; j < NRNG; j++) begin : g_r
    logic active;
    if (j < NARROW) begin : g_base
      assign active = 1'b1;
    end else begin : g_ext
      assign active = wide;
    end
    assign in_now[j] = rng_arm[j] && active &&
                       ord_le(rng_lo[j], cnt_value, cnt_signed) &&
                       ord_le(cnt_value, rng_hi[j], cnt_signed);
    assign r_hit[j]  = rng_on && in_now[j] && !in_q[j];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      in_q <= '0;
    else if (rng_on) in_q <= in_now;
    else             in_q <= '0;
  end

  assign status = in_q;

  for (genvar k = 0; k < NE; k++) begin : g_h
    logic th, rh;
    if (k < NTGT) begin : g_tv
      assign th = t_hit[k];
    end else begin : g_tz
      assign th = 1'b0;
    end
    if (k < NRNG) begin : g_rv
      assign rh = r_hit[k];
    end else begin : g_rz
      assign rh = 1'b0;
    end
    assign hit[k] = mode_rng ? rh : th;
  end

endmodule

// File: rtl/ccu_arbiter.sv
module ccu_arbiter #(
  parameter int NE  = 48,
  parameter int IDW = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [NE-1:0]            hit,
  input  logic [NE-1:0][IDW-1:0]   tags,
  input  logic                     flush,
  input  logic                     irq_ready,
  output logic                     irq_valid,
  output logic [IDW-1:0]           irq_id,
  output logic [NE-1:0]            pend_o
);

  localparam int SW = (NE > 1) ? $clog2(NE) : 1;

  logic [NE-1:0]  pend_q, avail, take;
  logic [SW-1:0]  sel;
  logic           found;
  logic           out_v;
  logic [IDW-1:0] out_id;
  logic           out_free;

  assign avail    = flush ? '0 : (pend_q | hit);
  assign out_free = !out_v || irq_ready;

  // lowest-numbered candidate wins
  always_comb begin
    found = 1'b0;
    sel   = '0;
    for (int k = NE - 1; k >= 0; k--) begin
      if (avail[k]) begin
        found = 1'b1;
        sel   = SW'(k);
      end
    end
  end

  assign take = found ? (NE'(1) << sel) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      out_v  <= 1'b0;
      out_id <= '0;
    end else if (out_free) begin
      out_v  <= found;
      if (found) out_id <= tags[sel];
      pend_q <= avail & ~take;
    end else begin
      pend_q <= avail;
    end
  end

  assign irq_valid = out_v;
  assign irq_id    = out_id;
  assign pend_o    = pend_q;

endmodule

// File: rtl/cnt_cmp_unit.sv
module cnt_cmp_unit #(
  parameter int CW     = 32,
  parameter int IDW    = 8,
  parameter int NTGT   = 48,
  parameter int NRNG   = 32,
  parameter int NARROW = 8,
  localparam int NE    = (NTGT > NRNG) ? NTGT : NRNG,
  localparam int IW    = (NE > 1) ? $clog2(NE) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CW-1:0]     cnt_value,
  input  logic              cnt_signed,
  input  logic              cnt_clear,
  input  logic              wr_en,
  input  logic [2:0]        wr_kind,
  input  logic [IW-1:0]     wr_idx,
  input  logic [CW-1:0]     wr_data,
  output logic              cmp_en_o,
  output logic [NRNG-1:0]   rng_status,
  output logic              irq_valid,
  input  logic              irq_ready,
  output logic [IDW-1:0]    irq_id
);

  logic                      en_q, mode_q, stop_q, wide_q, cfg_flush, en_eff;
  logic [NTGT-1:0][CW-1:0]   tgt_val;
  logic [NTGT-1:0][IDW-1:0]  tgt_tag;
  logic [NTGT-1:0]           tgt_arm;
  logic [NRNG-1:0][CW-1:0]   rng_lo, rng_hi;
  logic [NRNG-1:0][IDW-1:0]  rng_tag;
  logic [NRNG-1:0]           rng_arm;
  logic [NE-1:0]             hit, pend_w;
  logic [NE-1:0][IDW-1:0]    tags;

  ccu_regs #(.CW(CW), .IDW(IDW), .NTGT(NTGT), .NRNG(NRNG), .IW(IW)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .cnt_clear(cnt_clear),
    .en_q(en_q), .mode_q(mode_q), .stop_q(stop_q), .wide_q(wide_q), .cfg_flush(cfg_flush),
    .tgt_val(tgt_val), .tgt_tag(tgt_tag), .tgt_arm(tgt_arm),
    .rng_lo(rng_lo), .rng_hi(rng_hi), .rng_tag(rng_tag), .rng_arm(rng_arm)
  );

  // a stopping counter reset suppresses the sample it arrives with
  assign en_eff = en_q && !(cnt_clear && stop_q);

  ccu_match #(.CW(CW), .NTGT(NTGT), .NRNG(NRNG), .NARROW(NARROW), .NE(NE)) u_match (
    .clk(clk), .rst_n(rst_n), .cnt_value(cnt_value), .cnt_signed(cnt_signed),
    .en_eff(en_eff), .mode_rng(mode_q), .wide(wide_q),
    .tgt_val(tgt_val), .tgt_arm(tgt_arm),
    .rng_lo(rng_lo), .rng_hi(rng_hi), .rng_arm(rng_arm),
    .hit(hit), .status(rng_status)
  );

  for (genvar k = 0; k < NE; k++) begin : g_tag
    logic [IDW-1:0] tt, rt;
    if (k < NTGT) begin : g_tv
      assign tt = tgt_tag[k];
    end else begin : g_tz
      assign tt = '0;
    end
    if (k < NRNG) begin : g_rv
      assign rt = rng_tag[k];
    end else begin : g_rz
      assign rt = '0;
    end
    assign tags[k] = mode_q ? rt : tt;
  end

  ccu_arbiter #(.NE(NE), .IDW(IDW)) u_arb (
    .clk(clk), .rst_n(rst_n), .hit(hit), .tags(tags), .flush(cfg_flush),
    .irq_ready(irq_ready), .irq_valid(irq_valid), .irq_id(irq_id), .pend_o(pend_w)
  );

  assign cmp_en_o = en_q;

endmodule

// File: rtl/ccu_checker.sv
module ccu_checker #(
  parameter int NRNG   = 32,
  parameter int NARROW = 8,
  parameter int IDW    = 8,
  parameter int NE     = 48
) (
  input logic              clk,
  input logic              rst_n,
  input logic              irq_valid,
  input logic              irq_ready,
  input logic [IDW-1:0]    irq_id,
  input logic              cmp_en_o,
  input logic [NRNG-1:0]   rng_status,
  input logic              cnt_clear,
  input logic              stop_q,
  input logic              wide_q,
  input logic [NE-1:0]     pend
);

  a_r9_id_held: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ready |=> irq_valid && $stable(irq_id));

  a_r7_stop_drops_enable: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_clear && stop_q |=> !cmp_en_o);

  a_r10_status_clear_when_off: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en_o |=> rng_status == '0);

  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en_o && !irq_valid && pend == '0 |=> !irq_valid);

  a_r6_narrow_upper_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_q |=> rng_status[NRNG-1:NARROW] == '0);

endmodule

bind cnt_cmp_unit ccu_checker #(.NRNG(NRNG), .NARROW(NARROW), .IDW(IDW), .NE(NE)) u_chk (
  .clk(clk), .rst_n(rst_n), .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_id(irq_id),
  .cmp_en_o(cmp_en_o), .rng_status(rng_status), .cnt_clear(cnt_clear),
  .stop_q(stop_q), .wide_q(wide_q), .pend(pend_w)
);

// File: tb/cnt_cmp_unit_test.sv
`timescale 1ns/1ps
module cnt_cmp_unit_test;
  localparam int CW = 32, IDW = 6, NTGT = 6, NRNG = 8, NARROW = 4, IW = 3;
  localparam int ARM = 1 << IDW;

  logic clk = 0, rst_n = 0;
  logic [CW-1:0] cnt_value = '0;
  logic cnt_signed = 0, cnt_clear = 0, wr_en = 0, irq_ready = 1;
  logic [2:0] wr_kind = '0;
  logic [IW-1:0] wr_idx = '0;
  logic [CW-1:0] wr_data = '0;
  logic cmp_en_o, irq_valid;
  logic [NRNG-1:0] rng_status;
  logic [IDW-1:0] irq_id;

  int checks = 0, errors = 0;
  int got [0:511];
  int got_n = 0;

  cnt_cmp_unit #(.CW(CW), .IDW(IDW), .NTGT(NTGT), .NRNG(NRNG), .NARROW(NARROW)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_value(cnt_value), .cnt_signed(cnt_signed),
    .cnt_clear(cnt_clear), .wr_en(wr_en), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .cmp_en_o(cmp_en_o), .rng_status(rng_status),
    .irq_valid(irq_valid), .irq_ready(irq_ready), .irq_id(irq_id));

  always #10 clk = ~clk;

  // record accepted events; inputs only change 2 ns after a rising edge
  always @(negedge clk)
    if (rst_n && irq_valid && irq_ready && got_n < 512) begin
      got[got_n] = int'(irq_id);
      got_n++;
    end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input int kind, input int idx, input int data);
    wr_en = 1; wr_kind = 3'(kind); wr_idx = IW'(idx); wr_data = CW'(data);
    tick();
    wr_en = 0;
  endtask

  task automatic setc(input int v);
    cnt_value = CW'(v);
    tick();
  endtask

  function automatic bit inside_w(int v, int lo, int hi, bit sgn);
    logic [31:0] uv, ul, uh;
    uv = v; ul = lo; uh = hi;
    if (sgn) return (v >= lo) && (v <= hi);
    return (uv >= ul) && (uv <= uh);
  endfunction

  task automatic rng_sweep(input bit sgn, input bit wide, input string req);
    int prev, expm, evm, s;
    wr(0, 0, 0);
    cnt_signed = sgn;
    setc(-16);
    wr(0, 0, 1 | 2 | (wide ? 8 : 0));
    prev = 0;
    for (int v = -16; v <= 30; v++) begin
      s = got_n;
      setc(v);
      repeat (10) tick();
      expm = 0;
      for (int j = 0; j < NRNG; j++)
        if (j != 6 && (wide || j < NARROW) && inside_w(v, 4*j - 10, 4*j - 4, sgn))
          expm |= 1 << j;
      evm = 0;
      for (int e = s; e < got_n; e++) evm |= 1 << (got[e] - 40);
      chk(int'(rng_status) == expm, {req, " status R4 R6"}, rng_status, expm);
      chk(evm == (expm & ~prev) && (got_n - s) == $countones(expm & ~prev),
          {req, " entry events R5"}, evm, expm & ~prev);
      prev = expm;
    end
  endtask

  initial begin
    #4_000_000;
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int s, id0;
    bit stable;
    repeat (3) tick();
    // R1 reset state
    chk(cmp_en_o == 0 && irq_valid == 0 && rng_status == 0, "R1 reset",
        {cmp_en_o, irq_valid, rng_status}, 0);
    rst_n = 1;
    tick();

    // R3: targets 5+4i, tags 20+i, entry 3 left unarmed
    for (int i = 0; i < NTGT; i++) begin
      wr(1, i, 5 + 4*i);
      wr(2, i, (20 + i) | (i == 3 ? 0 : ARM));
    end
    wr(0, 0, 1);
    chk(cmp_en_o == 1, "R3 control write", cmp_en_o, 1);
    s = got_n;
    for (int v = 0; v <= 30; v++) setc(v);
    repeat (4) tick();
    chk(got_n - s == 5, "R2 R3 sweep event count", got_n - s, 5);
    begin
      int exp_ids [5] = '{20, 21, 22, 24, 25};
      for (int e = 0; e < 5; e++)
        chk(got[s+e] == exp_ids[e], "R2 R3 sweep event tag", got[s+e], exp_ids[e]);
    end

    // R2 no repeat while held
    s = got_n;
    setc(5);
    repeat (5) tick();
    chk(got_n - s == 1 && got[s] == 20, "R2 single event while held", got_n - s, 1);

    // R7 stop on reset
    wr(0, 0, 1 | 4);
    setc(7);
    s = got_n;
    cnt_clear = 1; cnt_value = 5; tick(); cnt_clear = 0;
    repeat (4) tick();
    chk(got_n == s, "R7 stop suppresses sample", got_n - s, 0);
    chk(cmp_en_o == 0, "R7 stop clears enable", cmp_en_o, 0);
    wr(0, 0, 1);
    setc(7);
    s = got_n;
    cnt_clear = 1; cnt_value = 5; tick(); cnt_clear = 0;
    repeat (4) tick();
    chk(got_n - s == 1 && got[s] == 20, "R7 continue compares", got_n - s, 1);
    chk(cmp_en_o == 1, "R7 continue keeps enable", cmp_en_o, 1);

    // R10 disabled
    wr(0, 0, 0);
    s = got_n;
    for (int v = 0; v <= 30; v++) setc(v);
    repeat (4) tick();
    chk(got_n == s, "R10 no events when off", got_n - s, 0);
    chk(rng_status == 0, "R10 status zero when off", rng_status, 0);

    // R8 R9 simultaneous match under back-pressure
    wr(1, 1, 21);
    wr(1, 5, 21);
    wr(0, 0, 1);
    setc(20);
    irq_ready = 0;
    s = got_n;
    setc(21);
    chk(irq_valid == 1 && irq_id == 21, "R8 lowest first", irq_id, 21);
    id0 = int'(irq_id);
    stable = 1;
    for (int c = 0; c < 4; c++) begin
      tick();
      if (!irq_valid || int'(irq_id) != id0) stable = 0;
    end
    chk(stable, "R9 held under stall", irq_id, id0);
    irq_ready = 1;
    repeat (5) tick();
    chk(got_n - s == 3, "R8 all delivered", got_n - s, 3);
    chk(got[s] == 21 && got[s+1] == 24 && got[s+2] == 25, "R8 ascending order",
        got[s+1], 24);

    // R11 config change flushes pending
    irq_ready = 0;
    setc(20);
    s = got_n;
    setc(21);
    wr(0, 0, 1 | 2);
    irq_ready = 1;
    repeat (5) tick();
    chk(got_n - s == 1, "R11 pending discarded", got_n - s, 1);
    chk(got[s] == 21, "R11 presented event kept", got[s], 21);
    wr(0, 0, 0);

    // range table: lower 4j-10, upper 4j-4, tags 40+j, entry 6 unarmed
    for (int j = 0; j < NRNG; j++) begin
      wr(3, j, 4*j - 10);
      wr(4, j, 4*j - 4);
      wr(5, j, (40 + j) | (j == 6 ? 0 : ARM));
    end
    rng_sweep(1, 1, "signed wide");
    rng_sweep(0, 0, "unsigned narrow");
    rng_sweep(0, 1, "unsigned wide");
    wr(0, 0, 0);
    tick();
    chk(rng_status == 0, "R10 status cleared after disable", rng_status, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule